// File: doc/BRIEF.md
# Segmented Pipelined Wakeup Window

This block is the wakeup half of an instruction issue window. It holds up to 32 waiting instructions. Each entry keeps a valid bit and two source operand tags, and each operand has its own ready bit. Every cycle, up to four completed-result tags are broadcast, each with its own valid bit. An entry whose source tag matches a valid broadcast tag marks that operand ready. An entry requests issue when it is valid and both of its operands are ready.

The entries are split into `SEGS` consecutive segments of `ceil(ENTRIES/SEGS)` entries each. Entry `i` belongs to segment `i / ceil(ENTRIES/SEGS)`. Broadcast tags reach segment 0 in the cycle they are presented. Registers between segments then carry the tags onward, so segment `k` (counting from 0) compares them `k` cycles later. A tag is seen by exactly one segment per cycle. No wire has to span the whole window in one cycle, and the price is a wakeup delay that depends on where an entry sits. With `SEGS = 1` the window behaves as a conventional window with a single-cycle global broadcast.

An allocator outside the block chooses the entry index for each insert. An external selector reads the request vector and returns a one-cycle grant bit for each entry it issues. The grant removes that entry from the window.

Top module: `wk_window`

## Requirements
- R1: After reset every bit of `req` is 0 and every entry is empty.
- R2: An insert to index `i` whose two operand ready flags are both 1 makes `req[i]` 1 at the clock edge that writes the entry.
- R3: A valid broadcast tag that equals a waiting source tag of an entry in segment 0 sets that operand ready at the edge that ends the broadcast cycle. If the other operand is already ready, `req` rises at that edge.
- R4: An entry in segment `k` is woken by a broadcast exactly `k` cycles later than an entry in segment 0 would be, with segment `k = i / ceil(ENTRIES/SEGS)`. Its `req` stays 0 in each of the `k` cycles before that.
- R5: An entry requests issue only when both operands are ready. A match on one operand alone leaves `req` at 0.
- R6: An insert compares its source tags against the tags its segment sees in that same cycle, so a wakeup that arrives during the insert is not missed. A tag that has already passed the segment does not wake the new entry.
- R7: A grant bit for index `i` clears the entry, and `req[i]` is 0 after that edge. If an insert to the same index happens in the same cycle, the insert takes precedence.
- R8: Any of the `NB` broadcast lanes can wake an entry. A lane whose valid bit is 0 has no effect, whatever its tag is. Lane `l` occupies bits `[l*TAG_W +: TAG_W]` of `bc_tag`.
- R9: Operand ready state is sticky. Once `req[i]` is 1, it stays 1 until a grant or a new insert to index `i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_idx | input | IDX_W | Entry index written by the insert |
| ins_t0 | input | TAG_W | Source operand 0 tag |
| ins_r0 | input | 1 | Source operand 0 already ready |
| ins_t1 | input | TAG_W | Source operand 1 tag |
| ins_r1 | input | 1 | Source operand 1 already ready |
| bc_valid | input | NB | Valid bit for each broadcast lane |
| bc_tag | input | NB*TAG_W | Broadcast destination tags, one field per lane |
| grant | input | ENTRIES | One-cycle issue grant for each entry; removes the entry |
| req | output | ENTRIES | Issue request for each entry |

## Verification
The properties assume the inputs stay inside what an issue queue would really present. Broadcast valid bits are held low during reset. An insert index is always below `ENTRIES`. Grants arrive only as single-cycle pulses. The stimulus drives every input on the falling clock edge and returns broadcast and grant lines to 0 after one cycle. It keeps at most a few entries live at once, with tags chosen so that no stray broadcast can match a waiting entry by accident. The stimulus also keeps broadcasts at zero while reset is active. This holds the inter-segment registers, and so the delay-line property, at their reset values.

// File: rtl/wk_pkg.sv
package wk_pkg;
  // Segment number that owns entry idx, given eps entries per segment.
  function automatic int wk_seg_of(input int idx, input int eps);
    return idx / eps;
  endfunction

  // Next ready state of one operand: recorded state OR a fresh tag match.
  function automatic logic wk_next_rdy(input logic cur, input logic hit);
    return cur | hit;
  endfunction
endpackage

// File: rtl/wk_tag_pipe.sv
module wk_tag_pipe #(
  parameter int SEGS  = 4,
  parameter int NB    = 4,
  parameter int TAG_W = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NB-1:0]                       in_v,
  input  logic [NB*TAG_W-1:0]                 in_t,
  output logic [SEGS-1:0][NB-1:0]             seg_v,
  output logic [SEGS-1:0][NB*TAG_W-1:0]       seg_t
);
  assign seg_v[0] = in_v;
  assign seg_t[0] = in_t;

  for (genvar k = 1; k < SEGS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_v[k] <= '0;
        seg_t[k] <= '0;
      end else begin
        seg_v[k] <= seg_v[k-1];
        seg_t[k] <= seg_t[k-1];
      end
    end
  end
endmodule

// File: rtl/wk_entry.sv
module wk_entry
  import wk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int TAG_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_en,
  input  logic [TAG_W-1:0]     ins_t0,
  input  logic                 ins_r0,
  input  logic [TAG_W-1:0]     ins_t1,
  input  logic                 ins_r1,
  input  logic                 clr,
  input  logic [NB-1:0]        see_v,
  input  logic [NB*TAG_W-1:0]  see_t,
  output logic                 req,
  output logic                 wake_ev
);
  logic             vld, rdy0, rdy1;
  logic [TAG_W-1:0] tag0, tag1;
  logic [TAG_W-1:0] cmp0, cmp1;
  logic [NB-1:0]    m0, m1;
  logic             hit0, hit1;

  // An inserting entry compares its incoming tags, otherwise its stored ones.
  assign cmp0 = ins_en ? ins_t0 : tag0;
  assign cmp1 = ins_en ? ins_t1 : tag1;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign m0[l] = see_v[l] && (see_t[l*TAG_W +: TAG_W] == cmp0);
    assign m1[l] = see_v[l] && (see_t[l*TAG_W +: TAG_W] == cmp1);
  end
  assign hit0 = |m0;
  assign hit1 = |m1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      rdy0 <= 1'b0;
      rdy1 <= 1'b0;
      tag0 <= '0;
      tag1 <= '0;
    end else if (ins_en) begin
      vld  <= 1'b1;
      tag0 <= ins_t0;
      tag1 <= ins_t1;
      rdy0 <= wk_next_rdy(ins_r0, hit0);
      rdy1 <= wk_next_rdy(ins_r1, hit1);
    end else if (clr) begin
      vld  <= 1'b0;
      rdy0 <= 1'b0;
      rdy1 <= 1'b0;
    end else if (vld) begin
      rdy0 <= wk_next_rdy(rdy0, hit0);
      rdy1 <= wk_next_rdy(rdy1, hit1);
    end
  end

  assign req     = vld & rdy0 & rdy1;
  assign wake_ev = vld & ~ins_en & ~clr & ((~rdy0 & hit0) | (~rdy1 & hit1));
endmodule

// File: rtl/wk_window.sv
module wk_window
  import wk_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int SEGS    = 4,
  parameter int NB      = 4,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int EPS    = (ENTRIES + SEGS - 1) / SEGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [IDX_W-1:0]     ins_idx,
  input  logic [TAG_W-1:0]     ins_t0,
  input  logic                 ins_r0,
  input  logic [TAG_W-1:0]     ins_t1,
  input  logic                 ins_r1,
  input  logic [NB-1:0]        bc_valid,
  input  logic [NB*TAG_W-1:0]  bc_tag,
  input  logic [ENTRIES-1:0]   grant,
  output logic [ENTRIES-1:0]   req
);
  logic [SEGS-1:0][NB-1:0]       seg_v;
  logic [SEGS-1:0][NB*TAG_W-1:0] seg_t;
  logic [ENTRIES-1:0]            wake_ev;

  wk_tag_pipe #(.SEGS(SEGS), .NB(NB), .TAG_W(TAG_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(bc_valid), .in_t(bc_tag),
    .seg_v(seg_v), .seg_t(seg_t)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int SG = wk_seg_of(i, EPS);
    logic ins_here;
    assign ins_here = ins_valid && (ins_idx == IDX_W'(i));
    wk_entry #(.NB(NB), .TAG_W(TAG_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .ins_en(ins_here),
      .ins_t0(ins_t0), .ins_r0(ins_r0), .ins_t1(ins_t1), .ins_r1(ins_r1),
      .clr(grant[i]), .see_v(seg_v[SG]), .see_t(seg_t[SG]),
      .req(req[i]), .wake_ev(wake_ev[i])
    );
  end
endmodule

// File: rtl/wk_window_chk.sv
module wk_window_chk #(
  parameter int ENTRIES = 32,
  parameter int SEGS    = 4,
  parameter int NB      = 4,
  parameter int IDX_W   = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ins_valid,
  input logic [IDX_W-1:0]        ins_idx,
  input logic                    ins_r0,
  input logic                    ins_r1,
  input logic [ENTRIES-1:0]      grant,
  input logic [ENTRIES-1:0]      req,
  input logic [ENTRIES-1:0]      wake_ev,
  input logic [SEGS-1:0][NB-1:0] seg_v
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_e
    logic ins_at;
    assign ins_at = ins_valid && (ins_idx == IDX_W'(i));

    assert_ready_insert_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (ins_at && ins_r0 && ins_r1) |=> req[i]);

    assert_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $rose(req[i]) |-> $past(ins_at || wake_ev[i]));

    assert_grant_clears_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (grant[i] && !ins_at) |=> !req[i]);

    assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (req[i] && !grant[i] && !ins_at) |=> req[i]);
  end

  for (genvar k = 1; k < SEGS; k++) begin : g_s
    assert_stage_delay_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      seg_v[k] == $past(seg_v[k-1]));
  end
endmodule

bind wk_window wk_window_chk #(.ENTRIES(ENTRIES), .SEGS(SEGS), .NB(NB), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_idx(ins_idx),
  .ins_r0(ins_r0), .ins_r1(ins_r1), .grant(grant), .req(req),
  .wake_ev(wake_ev), .seg_v(seg_v)
);

// File: tb/tb_wk_window.sv
module tb_wk_window;
  localparam int ENTRIES = 32;
  localparam int SEGS    = 4;
  localparam int NB      = 4;
  localparam int TAG_W   = 6;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int EPS     = (ENTRIES + SEGS - 1) / SEGS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [IDX_W-1:0] ins_idx = '0;
  logic [TAG_W-1:0] ins_t0 = '0, ins_t1 = '0;
  logic ins_r0 = 1'b0, ins_r1 = 1'b0;
  logic [NB-1:0] bc_valid = '0;
  logic [NB*TAG_W-1:0] bc_tag = '0;
  logic [ENTRIES-1:0] grant = '0;
  logic [ENTRIES-1:0] req;

  always #5 clk = ~clk;

  wk_window #(.ENTRIES(ENTRIES), .SEGS(SEGS), .NB(NB), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_idx(ins_idx),
    .ins_t0(ins_t0), .ins_r0(ins_r0), .ins_t1(ins_t1), .ins_r1(ins_r1),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .grant(grant), .req(req)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Vector fields: {entry index[4:0], tag[5:0], lane[1:0]}
  localparam logic [12:0] VEC [10] = '{
    {5'd0, 6'd3, 2'd0},  {5'd7, 6'd9, 2'd1},  {5'd8, 6'd11, 2'd2},
    {5'd15, 6'd20, 2'd3}, {5'd16, 6'd33, 2'd0}, {5'd23, 6'd40, 2'd1},
    {5'd24, 6'd50, 2'd2}, {5'd31, 6'd63, 2'd3}, {5'd12, 6'd1, 2'd0},
    {5'd27, 6'd2, 2'd1}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input int idx, input int t0, input bit r0, input int t1, input bit r1);
    ins_valid = 1'b1; ins_idx = IDX_W'(idx);
    ins_t0 = TAG_W'(t0); ins_r0 = r0; ins_t1 = TAG_W'(t1); ins_r1 = r1;
  endtask

  task automatic bc(input int lane, input int tag, input bit v);
    bc_valid[lane] = v;
    bc_tag[lane*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  task automatic idle();
    ins_valid = 1'b0; bc_valid = '0; bc_tag = '0; grant = '0;
  endtask

  task automatic clear_all();
    idle(); grant = '1; tick(); idle(); tick();
  endtask

  initial begin
    repeat (3) tick();
    chk(req == '0, "R1 reset", req, 0);
    rst_n = 1'b1;
    tick();
    chk(req == '0, "R1 after reset", req, 0);

    // Table walk: segment delay per entry (R4, R3, R8, R7)
    for (int v = 0; v < 10; v++) begin
      int idx, tag, lane, seg;
      idx = int'(VEC[v][12:8]); tag = int'(VEC[v][7:2]); lane = int'(VEC[v][1:0]);
      seg = idx / EPS;
      put(idx, tag, 1'b0, 0, 1'b1); tick();
      idle(); bc(lane, tag, 1'b1); tick();
      idle();
      for (int d = 0; d <= seg; d++) begin
        chk(req[idx] == (d == seg), (seg == 0) ? "R3 seg0 wake" : "R4 seg delay",
            32'(req[idx]), 32'(d == seg));
        if (d != seg) tick();
      end
      chk(req == (ENTRIES'(1) << idx), "R4 only target", req, 32'(ENTRIES'(1) << idx));
      grant[idx] = 1'b1; tick(); idle();
      chk(req[idx] == 1'b0, "R7 grant clears", 32'(req[idx]), 0);
      tick();
    end

    // R2: insert ready instruction
    put(5, 0, 1'b1, 0, 1'b1); tick(); idle();
    chk(req[5] == 1'b1, "R2 ready insert", 32'(req[5]), 1);
    // R7: grant and insert on the same index, insert wins
    put(5, 0, 1'b1, 0, 1'b1); grant[5] = 1'b1; tick(); idle();
    chk(req[5] == 1'b1, "R7 insert over grant", 32'(req[5]), 1);
    clear_all();

    // R5 and R9: two operands, one at a time
    put(2, 44, 1'b0, 45, 1'b0); tick(); idle();
    bc(0, 44, 1'b1); tick(); idle(); tick();
    chk(req[2] == 1'b0, "R5 one operand", 32'(req[2]), 0);
    bc(1, 45, 1'b1); tick(); idle();
    chk(req[2] == 1'b1, "R5 both operands", 32'(req[2]), 1);
    repeat (4) tick();
    chk(req[2] == 1'b1, "R9 sticky", 32'(req[2]), 1);
    clear_all();

    // R6: insert in seg0 concurrent with its tag
    put(3, 30, 1'b0, 0, 1'b1); bc(2, 30, 1'b1); tick(); idle();
    chk(req[3] == 1'b1, "R6 seg0 same-cycle", 32'(req[3]), 1);
    clear_all();
    // R6: tag reaches segment 2 two cycles after broadcast; insert then
    bc(0, 31, 1'b1); tick(); idle(); tick();
    put(16, 31, 1'b0, 0, 1'b1); tick(); idle();
    chk(req[16] == 1'b1, "R6 seg2 catches passing tag", 32'(req[16]), 1);
    clear_all();
    // R6: insert one cycle too late misses the tag
    bc(0, 32, 1'b1); tick(); idle(); tick(); tick();
    put(17, 32, 1'b0, 0, 1'b1); tick(); idle(); repeat (4) tick();
    chk(req[17] == 1'b0, "R6 missed tag", 32'(req[17]), 0);
    clear_all();

    // R8: invalid lane ignored, valid lane 3 wakes
    put(26, 55, 1'b0, 0, 1'b1); tick(); idle();
    bc(1, 55, 1'b0); tick(); idle(); repeat (SEGS + 1) tick();
    chk(req[26] == 1'b0, "R8 invalid lane", 32'(req[26]), 0);
    bc(3, 55, 1'b1); tick(); idle(); repeat (26 / EPS) tick();
    chk(req[26] == 1'b1, "R8 lane3 wake", 32'(req[26]), 1);
    clear_all();

    // Back-to-back dependents in segment 0 (R3)
    put(1, 60, 1'b0, 0, 1'b1); tick();
    put(2, 61, 1'b0, 0, 1'b1); tick(); idle();
    bc(0, 60, 1'b1); tick(); idle();
    chk(req[2:1] == 2'b01, "R3 first dependent", 32'(req[2:1]), 1);
    bc(0, 61, 1'b1); tick(); idle();
    chk(req[2:1] == 2'b11, "R3 second dependent next cycle", 32'(req[2:1]), 3);
    clear_all();
    chk(req == '0, "R7 all cleared", req, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule